// File: doc/BRIEF.md
# Three-Port Bufferless Deflection Router

This block is the switching element of a bufferless on-chip network node with three ports. On every clock it takes whatever packets are present on its three inputs and sends each of them out on exactly one output on the next clock edge. No packet is ever held, so there is no queue, no credit and no back-pressure. Each packet carries a destination and a 4-bit priority. A lookup table, given as a parameter, turns the destination into a preferred output port.

When two or three packets prefer the same output, the highest-ranked one wins it. Every loser is deflected onto an output that no winner claimed, and its priority is raised by one, up to a ceiling of 15. A packet that has been pushed around the network for a long time therefore outranks fresher traffic at later nodes.

Both edges are valid/data pairs with no ready. A valid input is always accepted, and an output cannot be stalled. A downstream node must take every flit it is offered. An upstream node may present a flit on any port in any cycle.

Top module: `defl_router3`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, all `out_vld` bits are 0.
- R2: Every input flagged valid in cycle t appears on exactly one output in cycle t+1, and the number of valid outputs equals the number of valid inputs. No input is ever refused.
- R3: The flit layout is: bits [DEST_W-1:0] are the destination, the next 4 bits are the priority, and the upper PAY_W bits are the payload. Destination and payload leave the router unchanged.
- R4: The preferred port of a packet is the 2-bit entry `ROUTE_MAP[2*dest +: 2]`. By default this entry is dest mod 3. A packet that gets its preferred port keeps its priority unchanged.
- R5: Among valid packets that prefer the same port, the one with the higher priority gets it.
- R6: When priorities are equal, the packet on the lower-numbered input port wins.
- R7: Winners are settled first. Losers are then placed in ranking order, each on the lowest-numbered port that is still free. A loser never takes a port that a winner claimed.
- R8: A deflected packet leaves with its priority increased by 1.
- R9: A deflected packet whose priority is already 15 leaves with priority 15.
- R10: An input with its valid bit low produces no output, and its flit bits have no effect on any other packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 3 | Per-input packet present |
| in_flit | input | 3 x FLIT_W | Per-input packet: destination, priority, payload |
| out_vld | output | 3 | Per-output packet present (registered) |
| out_flit | output | 3 x FLIT_W | Per-output packet (registered) |

## Verification
The router keeps no state beyond its output register, so a wrong internal decision shows at the ports on the very next clock. It may appear as a missing or duplicated valid, a packet on the wrong port, or a priority off by one. A reference model compares all three output ports every cycle. Directed cases cover contention for one port, ties, three-way collisions, and the case where a loser must avoid a port a lower-ranked winner prefers. Saturated priorities are included. Long random traffic then covers the remaining mixes.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int NPORT    = 3;
  localparam int PRIO_W   = 4;
  localparam int PSEL_W   = 2;
  localparam int MAP_ENTS = 64;
  localparam logic [PRIO_W-1:0] PRIO_CEIL = '1;

  typedef logic [PSEL_W-1:0] psel_t;
  typedef logic [PRIO_W-1:0] prio_t;

  // destination d prefers port d mod 3
  function automatic logic [2*MAP_ENTS-1:0] mod3_map();
    logic [2*MAP_ENTS-1:0] m;
    m = '0;
    for (int d = 0; d < MAP_ENTS; d++) m[2*d +: 2] = PSEL_W'(d % NPORT);
    return m;
  endfunction
endpackage

// File: rtl/rtr_rank.sv
// Orders inputs: valid before invalid, higher priority first, lower index on ties.
module rtr_rank
  import rtr_pkg::*;
(
  input  logic [NPORT-1:0]             vld,
  input  prio_t [NPORT-1:0]            prio,
  output psel_t [NPORT-1:0]            order
);
  logic [NPORT-1:0][NPORT-1:0] beats;  // beats[i][j]: input i ranks above input j
  psel_t [NPORT-1:0] rank;

  for (genvar i = 0; i < NPORT; i++) begin : g_row
    for (genvar j = 0; j < NPORT; j++) begin : g_col
      if (i == j) begin : g_self
        assign beats[i][j] = 1'b0;
      end else begin : g_pair
        assign beats[i][j] = vld[i] &&
          (!vld[j] || (prio[i] > prio[j]) || ((prio[i] == prio[j]) && (i < j)));
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NPORT; j++)
        if (j != i && !beats[i][j]) rank[i] = rank[i] + psel_t'(1);
    end
  end

  always_comb begin
    order = '0;
    for (int r = 0; r < NPORT; r++)
      for (int i = 0; i < NPORT; i++)
        if (rank[i] == psel_t'(r)) order[r] = psel_t'(i);
  end
endmodule

// File: rtl/rtr_alloc.sv
// Two-pass port allocation: preferred ports in rank order, then deflections.
module rtr_alloc
  import rtr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             vld,
  input  psel_t [NPORT-1:0]            pref,
  input  psel_t [NPORT-1:0]            order,
  output psel_t [NPORT-1:0]            grant,
  output logic [NPORT-1:0]             defl
);
  logic [NPORT-1:0] taken;
  logic [NPORT-1:0] won;
  logic             found;
  psel_t            idx;

  always_comb begin
    taken = '0;
    won   = '0;
    grant = '0;
    defl  = '0;
    found = 1'b0;
    idx   = '0;
    for (int r = 0; r < NPORT; r++) begin
      idx = order[r];
      if (vld[idx] && !taken[pref[idx]]) begin
        taken[pref[idx]] = 1'b1;
        won[idx]         = 1'b1;
        grant[idx]       = pref[idx];
      end
    end
    for (int r = 0; r < NPORT; r++) begin
      idx = order[r];
      if (vld[idx] && !won[idx]) begin
        found     = 1'b0;
        defl[idx] = 1'b1;
        for (int p = 0; p < NPORT; p++) begin
          if (!found && !taken[p]) begin
            grant[idx] = psel_t'(p);
            taken[p]   = 1'b1;
            found      = 1'b1;
          end
        end
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    logic [NPORT-1:0] users;
    for (genvar i = 0; i < NPORT; i++) begin : g_use
      assign users[i] = vld[i] && (grant[i] == psel_t'(p));
    end
    // R2: no output port carries two packets
    a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(users));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_defl_chk
    // R7: a deflected packet never leaves on the port it asked for
    a_r7_defl_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[i] && defl[i]) |-> (grant[i] != pref[i]));
  end
endmodule

// File: rtl/rtr_bump.sv
// Saturating priority raise for a deflected packet.
module rtr_bump
  import rtr_pkg::*;
(
  input  prio_t prio_in,
  input  logic  defl,
  output prio_t prio_out
);
  always_comb begin
    if (defl && (prio_in != PRIO_CEIL)) prio_out = prio_in + prio_t'(1);
    else                                prio_out = prio_in;
  end
endmodule

// File: rtl/defl_router3.sv
module defl_router3
  import rtr_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int PAY_W  = 8,
  parameter logic [2*MAP_ENTS-1:0] ROUTE_MAP = rtr_pkg::mod3_map(),
  localparam int FLIT_W = PAY_W + PRIO_W + DEST_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NPORT-1:0]                in_vld,
  input  logic [NPORT-1:0][FLIT_W-1:0]    in_flit,
  output logic [NPORT-1:0]                out_vld,
  output logic [NPORT-1:0][FLIT_W-1:0]    out_flit
);
  localparam int PRIO_LSB = DEST_W;

  prio_t [NPORT-1:0] prio_in;
  prio_t [NPORT-1:0] prio_new;
  psel_t [NPORT-1:0] pref;
  psel_t [NPORT-1:0] order;
  psel_t [NPORT-1:0] grant;
  logic  [NPORT-1:0] defl;
  logic  [NPORT-1:0][FLIT_W-1:0] moved;
  logic  [NPORT-1:0]             nxt_vld;
  logic  [NPORT-1:0][FLIT_W-1:0] nxt_flit;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [DEST_W-1:0] dest;
    assign dest       = in_flit[i][DEST_W-1:0];
    assign prio_in[i] = in_flit[i][PRIO_LSB +: PRIO_W];
    assign pref[i]    = ROUTE_MAP[2*int'(dest) +: 2];

    rtr_bump u_bump (
      .prio_in  (prio_in[i]),
      .defl     (defl[i]),
      .prio_out (prio_new[i])
    );

    always_comb begin
      moved[i] = in_flit[i];
      moved[i][PRIO_LSB +: PRIO_W] = prio_new[i];
    end
  end

  rtr_rank u_rank (
    .vld   (in_vld),
    .prio  (prio_in),
    .order (order)
  );

  rtr_alloc u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (in_vld),
    .pref  (pref),
    .order (order),
    .grant (grant),
    .defl  (defl)
  );

  always_comb begin
    nxt_vld  = '0;
    nxt_flit = '0;
    for (int p = 0; p < NPORT; p++)
      for (int i = 0; i < NPORT; i++)
        if (in_vld[i] && (grant[i] == psel_t'(p))) begin
          nxt_vld[p]  = 1'b1;
          nxt_flit[p] = moved[i];
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_flit <= '0;
    end else begin
      out_vld  <= nxt_vld;
      out_flit <= nxt_flit;
    end
  end

  // R1: outputs quiet during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (out_vld == '0));

  // R2: packets are neither lost nor duplicated across the register
  a_r2_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(out_vld) == $countones($past(in_vld))));

  for (genvar i = 0; i < NPORT; i++) begin : g_rank_chk
    for (genvar j = 0; j < NPORT; j++) begin : g_vs
      if (i != j) begin : g_pair
        // R5 / R6: whoever holds a loser's preferred port outranks it
        a_r5_holder_outranks: assert property (@(posedge clk) disable iff (!rst_n)
          (in_vld[i] && defl[i] && in_vld[j] && !defl[j] && (pref[j] == pref[i]))
          |-> ((prio_in[j] > prio_in[i]) || ((prio_in[j] == prio_in[i]) && (j < i))));
      end
    end
  end
endmodule

// File: tb/defl_router3_tb_top.sv
`timescale 1ns/1ps
module defl_router3_tb_top;
  localparam int DW = 4;
  localparam int PW = 8;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [2:0] in_vld = '0;
  logic [2:0][FW-1:0] in_flit = '0;
  logic [2:0] out_vld;
  logic [2:0][FW-1:0] out_flit;

  int total = 0;
  int bad = 0;
  bit armed = 0;
  logic [2:0] exp_vld;
  logic [2:0][FW-1:0] exp_flit;
  string exp_tag;

  always #2 clk = ~clk;

  defl_router3 #(.DEST_W(DW), .PAY_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit),
    .out_vld(out_vld), .out_flit(out_flit)
  );

  function automatic logic [FW-1:0] mk(int dest, int prio, int pay);
    return {8'(pay), 4'(prio), 4'(dest)};
  endfunction

  task automatic chk(string tag, string what, logic [FW-1:0] act, logic [FW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  // reference: rank, claim preferred ports, then place losers
  task automatic model();
    int ord[3];
    int pr[3];
    int pf[3];
    int g[3];
    bit won[3];
    bit used[3];
    bit dfl[3];
    for (int i = 0; i < 3; i++) begin
      ord[i] = i; pr[i] = int'(in_flit[i][7:4]); pf[i] = int'(in_flit[i][3:0]) % 3;
      won[i] = 0; used[i] = 0; dfl[i] = 0; g[i] = 0;
    end
    for (int pass = 0; pass < 3; pass++)
      for (int b = 0; b < 2; b++) begin
        int a = ord[b]; int c = ord[b+1];
        bit c_first = in_vld[c] && (!in_vld[a] || pr[c] > pr[a] || (pr[c] == pr[a] && c < a));
        if (c_first) begin ord[b] = c; ord[b+1] = a; end
      end
    for (int r = 0; r < 3; r++) begin
      int k = ord[r];
      if (in_vld[k] && !used[pf[k]]) begin used[pf[k]] = 1; won[k] = 1; g[k] = pf[k]; end
    end
    for (int r = 0; r < 3; r++) begin
      int k = ord[r];
      if (in_vld[k] && !won[k]) begin
        bit done = 0;
        dfl[k] = 1;
        for (int p = 0; p < 3; p++)
          if (!done && !used[p]) begin g[k] = p; used[p] = 1; done = 1; end
      end
    end
    exp_vld = '0; exp_flit = '0;
    for (int i = 0; i < 3; i++)
      if (in_vld[i]) begin
        logic [FW-1:0] f = in_flit[i];
        if (dfl[i] && pr[i] < 15) f[7:4] = 4'(pr[i] + 1);
        exp_vld[g[i]] = 1'b1;
        exp_flit[g[i]] = f;
      end
  endtask

  task automatic compare();
    if (armed)
      for (int p = 0; p < 3; p++) begin
        chk(exp_tag, $sformatf("vld port%0d", p), FW'(out_vld[p]), FW'(exp_vld[p]));
        if (exp_vld[p]) chk(exp_tag, $sformatf("flit port%0d", p), out_flit[p], exp_flit[p]);
      end
  endtask

  task automatic step(logic [2:0] v, logic [FW-1:0] f0, logic [FW-1:0] f1,
                      logic [FW-1:0] f2, string tag);
    @(negedge clk);
    compare();
    in_vld = v; in_flit[0] = f0; in_flit[1] = f1; in_flit[2] = f2;
    model();
    exp_tag = tag;
    armed = 1;
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    in_flit = {mk(1, 9, 8'hAA), mk(2, 9, 8'hBB), mk(0, 9, 8'hCC)};
    in_vld = 3'b111;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R1", "out_vld in reset", FW'(out_vld), '0);
    end
    in_vld = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_vld after reset", FW'(out_vld), '0);

    // R4: lone packet, preferred port 1, priority kept
    step(3'b001, mk(4, 3, 8'h11), '0, '0, "R4");
    // R3: distinctive payloads, no contention (prefs 2,0,1)
    step(3'b111, mk(5, 2, 8'h5A), mk(6, 7, 8'hA5), mk(13, 0, 8'hFF), "R3");
    // R5: both want port 0, higher priority on input 2 wins
    step(3'b101, mk(0, 2, 8'h01), '0, mk(3, 7, 8'h02), "R5");
    // R6: equal priority, input 1 beats input 2 for port 1
    step(3'b110, '0, mk(1, 5, 8'h03), mk(1, 5, 8'h04), "R6");
    // R8: three-way fight for port 2, two deflections at +1
    step(3'b111, mk(2, 1, 8'h10), mk(5, 1, 8'h20), mk(8, 1, 8'h30), "R8");
    // R7: loser must not take port 0 that lower-ranked input 2 wins
    step(3'b111, mk(2, 9, 8'h40), mk(2, 8, 8'h50), mk(0, 1, 8'h60), "R7");
    // R9: deflected at ceiling stays 15
    step(3'b011, mk(0, 15, 8'h70), mk(0, 15, 8'h80), '0, "R9");
    step(3'b101, mk(1, 14, 8'h71), '0, mk(1, 15, 8'h81), "R9");
    // R10: invalid inputs with conflicting garbage do nothing
    step(3'b010, mk(2, 15, 8'hEE), mk(2, 0, 8'h90), mk(2, 15, 8'hDD), "R10");
    step(3'b000, mk(0, 15, 8'hEE), mk(0, 15, 8'hEE), mk(0, 15, 8'hEE), "R10");

    for (int n = 0; n < 2000; n++) begin
      logic [FW-1:0] f[3];
      for (int k = 0; k < 3; k++) begin
        int pz = ($urandom % 4 == 0) ? 14 + ($urandom % 2) : int'($urandom % 16);
        f[k] = mk(int'($urandom % 16), pz, int'($urandom % 256));
      end
      step(3'($urandom), f[0], f[1], f[2], "R2");
    end
    step(3'b000, '0, '0, '0, "R2");
    @(negedge clk);
    compare();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule